// File: doc/BRIEF.md
# Serial Command Decoder with Double-Buffered Converter Registers

This block is the write-only serial front end of a dual 10-bit converter. A host lowers an active-low select line, clocks in one 16-bit command word, most significant bit first, and raises the select line again. The top four bits of the word are an action code and the next ten bits are a data code. The decoded action moves data into two staging (input) registers. It can also move data into two converter registers, whose contents drive the analog converters, and it can change a sleep/wake state.

The serial clock and data are sampled by the block's own system clock, and edges are found by comparing each sample with the one before it. When the sixteenth bit has been taken in, the block drops a gate output that allows the serial input stages to be powered down. Only the next falling edge of the select line raises the gate again. A separate global power-on input, when low, forces an all-outputs-off indication, whatever sleep/wake state the commands have set.

Top module: `serial_cmd_slave`

## Requirements
- R1: After reset, converter A reads 10'h3AF, converter B reads 10'h028, sleep is 0, the input gate is 0, and all-off is 0 while global power-on is high.
- R2: A frame is 16 rising edges of the serial clock while select is low, starting after a falling edge of select. Bits go in MSB first. Word bits [15:12] are the action code, bits [11:2] are the data and bits [1:0] are ignored. The action takes effect one system clock after the 16th bit is sampled.
- R3: The input gate rises one clock after a falling edge of select and falls after the 16th bit. Further serial clocks before the next falling edge of select have no effect.
- R4: A frame in which select rises before the 16th bit is discarded, and the next frame starts counting from bit zero.
- R5: Codes 0000 and 1001 to 1111 change no register and leave the sleep state unchanged.
- R6: Code 0001 loads input A and code 0010 loads input B. The converter outputs and the sleep state are unchanged.
- R7: Code 0011 copies both input registers into both converter registers and clears sleep.
- R8: Code 0100 loads input A with the data, loads converter A with it and loads converter B from input B. Code 0101 does the same with the two channels swapped. Both codes clear sleep.
- R9: Code 1000 loads the data into both input registers and both converter registers and clears sleep.
- R10: Code 0110 clears sleep and code 0111 sets sleep. Neither touches any register.
- R11: all_off_o is 1 whenever global_on is 0 or sleep is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sel_n | input | 1 | Active-low select/load line framing a command |
| ser_clk | input | 1 | Serial bit clock, sampled on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| global_on | input | 1 | Global power-on; low forces all outputs off |
| conv_a_o | output | 10 | Converter register A |
| conv_b_o | output | 10 | Converter register B |
| sleep_o | output | 1 | Sleep state set by commands |
| rx_gate_o | output | 1 | High while the serial input stages must stay powered |
| all_off_o | output | 1 | All outputs off indication |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 4-bit code, a 10-bit data field and the two reset presets. With these values the two ignored low bits of the word exist, so sending them as ones shows that they are dropped. Because the data field is narrower than the word, a truncated 10-bit frame can be sent that holds a complete action code. The bench shows that such a frame and any clocks after the gate has closed leave the converter values unchanged.

// File: rtl/sc_cmd_pkg.sv
package sc_cmd_pkg;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        CMD_NOP      = 4'b0000,
        CMD_LD_A     = 4'b0001,
        CMD_LD_B     = 4'b0010,
        CMD_UPD      = 4'b0011,
        CMD_LD_A_UPD = 4'b0100,
        CMD_LD_B_UPD = 4'b0101,
        CMD_WAKE     = 4'b0110,
        CMD_SLEEP    = 4'b0111,
        CMD_LD_BOTH  = 4'b1000
    } cmd_e;
endpackage

// File: rtl/sc_shift_in.sv
module sc_shift_in #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sel_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    output logic              gate_o,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic              sel_n;
        logic              sclk;
        logic              gate;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shreg;
        logic              done;
    } st_t;

    st_t st_d, st_q;
    logic sel_fall, sclk_rise;

    always_comb begin
        sel_fall  = st_q.sel_n & ~frame_sel_n;
        sclk_rise = ser_clk & ~st_q.sclk;
        st_d       = st_q;
        st_d.sel_n = frame_sel_n;
        st_d.sclk  = ser_clk;
        st_d.done  = 1'b0;
        if (frame_sel_n) begin
            st_d.cnt = '0;
        end else if (sel_fall) begin
            st_d.gate = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.gate && sclk_rise) begin
            st_d.shreg = {st_q.shreg[WORD_W-2:0], ser_data};
            if (st_q.cnt == LAST) begin
                st_d.done = 1'b1;
                st_d.gate = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel_n <= 1'b1;
            st_q.sclk  <= 1'b1;
            st_q.gate  <= 1'b0;
            st_q.cnt   <= '0;
            st_q.shreg <= '0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o       = st_q.gate;
    assign word_valid_o = st_q.done;
    assign word_o       = st_q.shreg;

    p_gate_opens_on_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.gate) |-> ($past(st_q.sel_n) && !$past(frame_sel_n)));
    p_no_shift_when_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.gate |=> $stable(st_q.shreg));
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(WORD_W));
    p_short_frame_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sel_n |=> (st_q.cnt == '0));
endmodule

// File: rtl/sc_decode.sv
module sc_decode
    import sc_cmd_pkg::*;
#(
    parameter int              WORD_W   = 16,
    parameter int              DATA_W   = 10,
    parameter logic [DATA_W-1:0] PRESET_A = 10'h3AF,
    parameter logic [DATA_W-1:0] PRESET_B = 10'h028
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [DATA_W-1:0] conv_a_o,
    output logic [DATA_W-1:0] conv_b_o,
    output logic              sleep_o
);
    localparam int CODE_MSB = WORD_W - 1;
    localparam int DATA_MSB = WORD_W - CODE_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] in_a;
        logic [DATA_W-1:0] in_b;
        logic [DATA_W-1:0] cv_a;
        logic [DATA_W-1:0] cv_b;
        logic              sleep;
    } regs_t;

    regs_t r_d, r_q;
    logic [CODE_W-1:0] code_raw;
    logic [DATA_W-1:0] data;

    assign code_raw = word_i[CODE_MSB -: CODE_W];
    assign data     = word_i[DATA_MSB -: DATA_W];

    always_comb begin
        r_d = r_q;
        if (valid_i) begin
            case (cmd_e'(code_raw))
                CMD_LD_A: r_d.in_a = data;
                CMD_LD_B: r_d.in_b = data;
                CMD_UPD: begin
                    r_d.cv_a  = r_q.in_a;
                    r_d.cv_b  = r_q.in_b;
                    r_d.sleep = 1'b0;
                end
                CMD_LD_A_UPD: begin
                    r_d.in_a  = data;
                    r_d.cv_a  = data;
                    r_d.cv_b  = r_q.in_b;
                    r_d.sleep = 1'b0;
                end
                CMD_LD_B_UPD: begin
                    r_d.in_b  = data;
                    r_d.cv_b  = data;
                    r_d.cv_a  = r_q.in_a;
                    r_d.sleep = 1'b0;
                end
                CMD_WAKE:  r_d.sleep = 1'b0;
                CMD_SLEEP: r_d.sleep = 1'b1;
                CMD_LD_BOTH: begin
                    r_d.in_a  = data;
                    r_d.in_b  = data;
                    r_d.cv_a  = data;
                    r_d.cv_b  = data;
                    r_d.sleep = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.in_a  <= '0;
            r_q.in_b  <= '0;
            r_q.cv_a  <= PRESET_A;
            r_q.cv_b  <= PRESET_B;
            r_q.sleep <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign conv_a_o = r_q.cv_a;
    assign conv_b_o = r_q.cv_b;
    assign sleep_o  = r_q.sleep;

    p_conv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(conv_a_o) && $stable(conv_b_o)));
    p_noop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (code_raw == 4'b0000 || code_raw >= 4'b1001))
        |=> ($stable(r_q) ));
    p_sleep_by_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> ($past(valid_i) && $past(code_raw) == 4'b0111));
    p_update_wakes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (code_raw == 4'b0011 || code_raw == 4'b0100 ||
                     code_raw == 4'b0101 || code_raw == 4'b1000)) |=> !sleep_o);
endmodule

// File: rtl/serial_cmd_slave.sv
module serial_cmd_slave #(
    parameter int                WORD_W   = 16,
    parameter int                DATA_W   = 10,
    parameter logic [DATA_W-1:0] PRESET_A = 10'h3AF,
    parameter logic [DATA_W-1:0] PRESET_B = 10'h028
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sel_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              global_on,
    output logic [DATA_W-1:0] conv_a_o,
    output logic [DATA_W-1:0] conv_b_o,
    output logic              sleep_o,
    output logic              rx_gate_o,
    output logic              all_off_o
);
    logic              word_valid;
    logic [WORD_W-1:0] word;

    sc_shift_in #(.WORD_W(WORD_W)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_sel_n  (frame_sel_n),
        .ser_clk      (ser_clk),
        .ser_data     (ser_data),
        .gate_o       (rx_gate_o),
        .word_valid_o (word_valid),
        .word_o       (word)
    );

    sc_decode #(
        .WORD_W   (WORD_W),
        .DATA_W   (DATA_W),
        .PRESET_A (PRESET_A),
        .PRESET_B (PRESET_B)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (word_valid),
        .word_i   (word),
        .conv_a_o (conv_a_o),
        .conv_b_o (conv_b_o),
        .sleep_o  (sleep_o)
    );

    assign all_off_o = ~global_on | sleep_o;

    p_global_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !global_on |-> all_off_o);
endmodule

// File: tb/tb_serial_cmd_slave.sv
module tb_serial_cmd_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sel_n = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       global_on = 1'b1;
    logic [9:0] conv_a, conv_b;
    logic       sleep, rx_gate, all_off;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_cmd_slave dut (
        .clk(clk), .rst_n(rst_n), .frame_sel_n(frame_sel_n),
        .ser_clk(ser_clk), .ser_data(ser_data), .global_on(global_on),
        .conv_a_o(conv_a), .conv_b_o(conv_b), .sleep_o(sleep),
        .rx_gate_o(rx_gate), .all_off_o(all_off)
    );

    // Vector: code[34:31] data[30:21] expA[20:11] expB[10:1] expSleep[0]
    localparam int NV = 16;
    localparam logic [34:0] VEC [NV] = '{
        {4'b0001, 10'h155, 10'h3AF, 10'h028, 1'b0}, // R6 load A only
        {4'b0111, 10'h000, 10'h3AF, 10'h028, 1'b1}, // R10 sleep
        {4'b0010, 10'h0F0, 10'h3AF, 10'h028, 1'b1}, // R6 load B only
        {4'b0011, 10'h000, 10'h155, 10'h0F0, 1'b0}, // R7 update both
        {4'b0111, 10'h000, 10'h155, 10'h0F0, 1'b1}, // R10 sleep
        {4'b0110, 10'h3FF, 10'h155, 10'h0F0, 1'b0}, // R10 wake only
        {4'b0100, 10'h2AA, 10'h2AA, 10'h0F0, 1'b0}, // R8 load A + update
        {4'b0101, 10'h001, 10'h2AA, 10'h001, 1'b0}, // R8 load B + update
        {4'b0000, 10'h3FF, 10'h2AA, 10'h001, 1'b0}, // R5 nop
        {4'b1011, 10'h3FF, 10'h2AA, 10'h001, 1'b0}, // R5 unused
        {4'b1000, 10'h300, 10'h300, 10'h300, 1'b0}, // R9 same to both
        {4'b1111, 10'h123, 10'h300, 10'h300, 1'b0}, // R5 unused
        {4'b0011, 10'h000, 10'h300, 10'h300, 1'b0}, // R9 inputs loaded too
        {4'b0111, 10'h000, 10'h300, 10'h300, 1'b1}, // R10 sleep
        {4'b0001, 10'h0AB, 10'h300, 10'h300, 1'b1}, // R6
        {4'b0011, 10'h000, 10'h0AB, 10'h300, 1'b0}  // R7 B from old input
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_low();
        @(negedge clk); frame_sel_n = 1'b0; wclk(2);
    endtask

    task automatic sel_high();
        @(negedge clk); frame_sel_n = 1'b1; wclk(4);
    endtask

    task automatic shift_bits(input logic [15:0] w, input int n);
        for (int i = 15; i > 15 - n; i--) begin
            ser_data = w[i]; wclk(2);
            ser_clk = 1'b1;  wclk(2);
            ser_clk = 1'b0;  wclk(2);
        end
    endtask

    task automatic send(input logic [3:0] code, input logic [9:0] data);
        sel_low();
        shift_bits({code, data, 2'b11}, 16);
        sel_high();
    endtask

    task automatic expect_state(input string tag, input logic [9:0] a,
                                input logic [9:0] b, input logic s);
        chk({tag, " conv_a"}, int'(conv_a), int'(a));
        chk({tag, " conv_b"}, int'(conv_b), int'(b));
        chk({tag, " sleep"}, int'(sleep), int'(s));
    endtask

    initial begin
        wclk(3);
        rst_n = 1'b1;
        wclk(2);
        // R1 reset state
        expect_state("R1", 10'h3AF, 10'h028, 1'b0);
        chk("R1 gate", int'(rx_gate), 0);
        chk("R1 all_off", int'(all_off), 0);

        // R2 table walk, low ignored bits sent as ones
        for (int k = 0; k < NV; k++) begin
            send(VEC[k][34:31], VEC[k][30:21]);
            expect_state($sformatf("R2 vec%0d", k), VEC[k][20:11], VEC[k][10:1], VEC[k][0]);
        end

        // R3 gate behaviour and clocks after the 16th bit
        sel_low();
        chk("R3 gate open", int'(rx_gate), 1);
        shift_bits({4'b0111, 10'h000, 2'b00}, 16);
        chk("R3 gate closed", int'(rx_gate), 0);
        chk("R3 sleep took", int'(sleep), 1);
        shift_bits({4'b1000, 10'h011, 2'b00}, 16);
        sel_high();
        expect_state("R3 extra clocks ignored", 10'h0AB, 10'h300, 1'b1);

        // R4 short frame discarded, next frame counts from zero
        sel_low();
        shift_bits({4'b1000, 10'h022, 2'b00}, 10);
        sel_high();
        expect_state("R4 short frame", 10'h0AB, 10'h300, 1'b1);
        send(4'b1000, 10'h044);
        expect_state("R4 next frame", 10'h044, 10'h044, 1'b0);

        // R11 all-off from sleep and from global power-on
        send(4'b0111, 10'h000);
        chk("R11 sleep all_off", int'(all_off), 1);
        send(4'b0110, 10'h000);
        chk("R11 wake all_off", int'(all_off), 0);
        @(negedge clk); global_on = 1'b0; wclk(1);
        chk("R11 global all_off", int'(all_off), 1);
        chk("R11 sleep unchanged", int'(sleep), 0);
        global_on = 1'b1; wclk(1);
        chk("R11 release", int'(all_off), 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule